// File: doc/BRIEF.md
# Banked Clock Divider Selector

This block turns one fast source clock into twelve clock lines arranged as four banks of three. A two-stage divider chain makes a half-rate clock and a quarter-rate clock, each with an even 50% duty cycle. Each bank carries one of those two clocks. A 2-bit select code picks how many of the lower banks run at the quarter rate. The top bank always runs at the half rate.

Every line can be tri-stated with one active-low enable. A test input bypasses the dividers and sends an external bypass clock straight to every line. A synchronous clear puts the divider chain back to its start phase.

A settle timer counts source-clock cycles after reset, after a select change and after the outputs are re-enabled. While it runs it holds a `settled` flag low. Downstream logic waits for this flag before it trusts the lines. Select changes are captured on the source clock and take effect only at the point where both derived clocks are low. This keeps runt pulses off the lines.

Top module: `clkbank_divsel`

## Requirements
- R1: The half-rate clock toggles on every source rising edge, and the quarter-rate clock toggles on the source edge where the half-rate clock goes from 0 to 1. After reset or clear, both clocks therefore rise together on the first edge, and both have a 50% duty cycle.
- R2: Bank b (b = 0..3) drives lines `clk_out[3b+2:3b]`. With an applied select code k (0..3), banks with index below k carry the quarter-rate clock and the other banks carry the half-rate clock. Code 0 puts every bank at half rate, and code 3 puts banks 0, 1 and 2 at quarter rate.
- R3: Bank 3 (`clk_out[11:9]`) carries the half-rate clock for every select code.
- R4: While `out_en_n` is 1, all twelve lines are high impedance. While it is 0, all lines drive.
- R5: While `byp_mode` is 1 and the outputs are enabled, every line equals `byp_clk` combinationally, and the divided clocks do not reach the lines.
- R6: `clr` high at a source edge sets both divided clocks to 0 after that edge. When `clr` is released, the chain restarts with a common rising edge.
- R7: `bank_sel` is registered on every source edge. The registered code becomes the applied code only at an edge after which both divided clocks are 0, or at an edge with `clr` high. At any other edge the applied code holds.
- R8: `settled` is 0 from reset until SETTLE_CYC source edges after reset release. Each of two events restarts the full count from the edge that sees it: a registered select change, or `out_en_n` seen at 0 one edge after it was seen at 1. A new event during a count restarts the count.
- R9: During reset, with the outputs enabled and no bypass, all lines are 0 and `settled` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the divider chain |
| bank_sel | input | 2 | Count of lower banks that run at quarter rate |
| out_en_n | input | 1 | Active-low output enable for all lines |
| byp_mode | input | 1 | 1 sends byp_clk to every line |
| byp_clk | input | 1 | Clock used while bypassing |
| clk_out | output | 12 | Four banks of three clock lines, tri-state |
| settled | output | 1 | 1 once the settle period has elapsed |

## Verification
The hardest case to reach from the ports is a select change that lands at each of the four phases of the quarter-rate cycle. Such a change must be held back until both clocks are low, and meanwhile a second event must restart the settle count. The bench steps the chain with a phase model of its own. It changes the code on successive edges so that the change arrives at every phase. It also issues a second select change and an enable fall part-way through a count, then follows `settled` edge by edge against the model's count.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

  typedef enum logic {
    RATE_FAST = 1'b0,
    RATE_SLOW = 1'b1
  } rate_e;

  // Thermometer assignment: banks below the code run slow; the top bank never does.
  function automatic rate_e bank_rate(input int unsigned bank,
                                      input int unsigned code,
                                      input int unsigned nbanks);
    if (bank == nbanks - 1) return RATE_FAST;
    return (bank < code) ? RATE_SLOW : RATE_FAST;
  endfunction

endpackage

// File: rtl/clkbank_div.sv
module clkbank_div (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic half_q,
  output logic quarter_q,
  output logic safe_pt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   half_q <= 1'b0;
    else if (clr) half_q <= 1'b0;
    else          half_q <= ~half_q;
  end

  // Quarter stage toggles on the edge where the half stage rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       quarter_q <= 1'b0;
    else if (clr)     quarter_q <= 1'b0;
    else if (!half_q) quarter_q <= ~quarter_q;
  end

  // Next edge leaves both stages low.
  assign safe_pt = clr | (half_q & ~quarter_q);

endmodule

// File: rtl/clkbank_selsync.sv
module clkbank_selsync
  import clkbank_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     sel_in,
  input  logic                 load,
  output logic                 sel_chg,
  output logic [SEL_W-1:0]     sel_live,
  output logic [NUM_BANKS-1:0] slow_mask
);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_live <= '0;
    else if (load) sel_live <= sel_q;
  end

  assign sel_chg = (sel_in != sel_q);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign slow_mask[b] = (bank_rate(b, int'(sel_live), NUM_BANKS) == RATE_SLOW);
  end

endmodule

// File: rtl/clkbank_settle.sv
module clkbank_settle #(
  parameter int SETTLE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic ready
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= CNT_LOAD;
    else if (restart)      remain <= CNT_LOAD;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign ready = (remain == '0);

endmodule

// File: rtl/clkbank_divsel.sv
module clkbank_divsel #(
  parameter int NUM_BANKS      = 4,
  parameter int LINES_PER_BANK = 3,
  parameter int SEL_W          = 2,
  parameter int SETTLE_CYC     = 10000
) (
  input  logic                                clk_src,
  input  logic                                rst_n,
  input  logic                                clr,
  input  logic [SEL_W-1:0]                    bank_sel,
  input  logic                                out_en_n,
  input  logic                                byp_mode,
  input  logic                                byp_clk,
  output wire  [NUM_BANKS*LINES_PER_BANK-1:0] clk_out,
  output logic                                settled
);

  localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

  logic                 div2, div4, safe_pt;
  logic                 sel_chg;
  logic [SEL_W-1:0]     sel_live;
  logic [NUM_BANKS-1:0] slow_mask;
  logic                 oe_q, oe_fall, restart;
  logic [NUM_LINES-1:0] line_val;

  clkbank_div u_div (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .clr       (clr),
    .half_q    (div2),
    .quarter_q (div4),
    .safe_pt   (safe_pt)
  );

  clkbank_selsync #(
    .SEL_W     (SEL_W),
    .NUM_BANKS (NUM_BANKS)
  ) u_sel (
    .clk       (clk_src),
    .rst_n     (rst_n),
    .sel_in    (bank_sel),
    .load      (safe_pt),
    .sel_chg   (sel_chg),
    .sel_live  (sel_live),
    .slow_mask (slow_mask)
  );

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= out_en_n;
  end

  assign oe_fall = oe_q & ~out_en_n;
  assign restart = sel_chg | oe_fall;

  clkbank_settle #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_settle (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .restart (restart),
    .ready   (settled)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LINES_PER_BANK; l++) begin : g_line
      assign line_val[b*LINES_PER_BANK + l] =
        byp_mode ? byp_clk : (slow_mask[b] ? div4 : div2);
      assign clk_out[b*LINES_PER_BANK + l] =
        out_en_n ? 1'bz : line_val[b*LINES_PER_BANK + l];
    end
  end

endmodule

// File: rtl/clkbank_divsel_chk.sv
module clkbank_divsel_chk #(
  parameter int NUM_LINES      = 12,
  parameter int LINES_PER_BANK = 3,
  parameter int SEL_W          = 2
) (
  input logic                 clk_src,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 out_en_n,
  input logic                 byp_mode,
  input logic                 div2,
  input logic                 div4,
  input logic [SEL_W-1:0]     sel_live,
  input logic                 sel_chg,
  input logic [NUM_LINES-1:0] line_val,
  input logic                 settled
);

  p_half_toggle_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
    !clr |=> (div2 != $past(div2)));

  p_quarter_on_rise_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!clr && !div2) |=> (div4 != $past(div4)));

  p_quarter_hold_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!clr && div2) |=> $stable(div4));

  p_clear_low_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
    clr |=> (!div2 && !div4));

  p_sel_safe_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!clr && !(div2 && !div4)) |=> $stable(sel_live));

  p_top_bank_fast_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
    !byp_mode |-> (line_val[NUM_LINES-1 -: LINES_PER_BANK] == {LINES_PER_BANK{div2}}));

  p_sel_unsettle_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
    sel_chg |=> !settled);

  p_oe_unsettle_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
    out_en_n ##1 !out_en_n |=> !settled);

endmodule

bind clkbank_divsel clkbank_divsel_chk #(
  .NUM_LINES      (NUM_LINES),
  .LINES_PER_BANK (LINES_PER_BANK),
  .SEL_W          (SEL_W)
) u_chk (
  .clk_src  (clk_src),
  .rst_n    (rst_n),
  .clr      (clr),
  .out_en_n (out_en_n),
  .byp_mode (byp_mode),
  .div2     (div2),
  .div4     (div4),
  .sel_live (sel_live),
  .sel_chg  (sel_chg),
  .line_val (line_val),
  .settled  (settled)
);

// File: tb/clkbank_divsel_bench.sv
module clkbank_divsel_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_SET      = 20;
  localparam logic [11:0] PARK = 12'hA5A;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_d = 1'b0;
  logic [1:0] sel_d = 2'd0;
  logic       oe_d = 1'b0;
  logic       byp_d = 1'b0;
  logic       bclk_d = 1'b0;
  wire [11:0] y_bus;
  logic       settled;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // Bench parks a known pattern on the lines whenever the block should release them.
  assign y_bus = oe_d ? PARK : 12'bz;

  clkbank_divsel #(.SETTLE_CYC(N_SET)) u_clkbank_divsel (
    .clk_src  (clk),
    .rst_n    (rst_n),
    .clr      (clr_d),
    .bank_sel (sel_d),
    .out_en_n (oe_d),
    .byp_mode (byp_d),
    .byp_clk  (bclk_d),
    .clk_out  (y_bus),
    .settled  (settled)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model state, built from the requirements.
  int         m_ph = 0;
  logic [1:0] m_selq = 2'd0;
  logic [1:0] m_live = 2'd0;
  logic       m_oeq = 1'b0;
  int         m_cnt = N_SET;

  function automatic logic [11:0] exp_bus();
    logic h, q;
    logic [11:0] v;
    h = m_ph[0];
    q = m_ph[0] ^ m_ph[1];
    if (oe_d) return PARK;
    if (byp_d) return {12{bclk_d}};
    for (int b = 0; b < 4; b++) begin
      logic s;
      s = (b < 3) && (b < int'(m_live));
      v[b*3 +: 3] = {3{s ? q : h}};
    end
    return v;
  endfunction

  task automatic check_now(input string tag);
    logic [11:0] e;
    logic es;
    e  = exp_bus();
    es = (m_cnt == 0);
    n_vec++;
    if (y_bus !== e || settled !== es) begin
      n_bad++;
      $display("FAIL %s t=%0t lines=%h exp=%h settled=%b exp=%b",
               tag, $time, y_bus, e, settled, es);
    end
  endtask

  task automatic step(input string tag);
    logic trig;
    @(posedge clk);
    cyc++;
    trig = (sel_d != m_selq) || (m_oeq && !oe_d);
    if (trig) m_cnt = N_SET;
    else if (m_cnt > 0) m_cnt--;
    if (clr_d || m_ph == 3) m_live = m_selq;
    m_selq = sel_d;
    m_oeq  = oe_d;
    m_ph   = clr_d ? 0 : (m_ph + 1) % 4;
    #2;
    check_now(tag);
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(posedge clk); #2;
      n_vec++;
      if (y_bus !== 12'h000 || settled !== 1'b0) begin
        n_bad++;
        $display("FAIL R9 reset lines=%h exp=000 settled=%b exp=0", y_bus, settled);
      end
    end
    rst_n = 1'b1;
    for (int i = 0; i < N_SET + 4; i++) step("R8 R1 settle after reset");
  endtask

  task automatic t_codes();
    for (int k = 0; k < 4; k++) begin
      sel_d = 2'(k);
      for (int i = 0; i < 12; i++) step("R2 R3 R1 select code");
    end
    // Changes landing at each quarter phase.
    for (int p = 0; p < 4; p++) begin
      sel_d = 2'(p + 1);
      step("R7 change phase");
      sel_d = 2'(3 - p);
      for (int i = 0; i < 6; i++) step("R7 R2 delayed apply");
    end
  endtask

  task automatic t_clear();
    sel_d = 2'd3;
    for (int i = 0; i < 6; i++) step("R2 pre clear");
    clr_d = 1'b1;
    step("R6 clear");
    step("R6 clear held");
    clr_d = 1'b0;
    for (int i = 0; i < 10; i++) step("R6 R1 restart after clear");
  endtask

  task automatic t_bypass();
    byp_d = 1'b1;
    for (int i = 0; i < 6; i++) begin
      bclk_d = ~bclk_d;
      #1;
      check_now("R5 bypass follows");
      step("R5 bypass edge");
    end
    byp_d = 1'b0;
    #1;
    check_now("R5 bypass released");
  endtask

  task automatic t_settle();
    for (int i = 0; i < N_SET + 2; i++) step("R8 wait settled");
    sel_d = 2'd1;
    for (int i = 0; i < N_SET / 2; i++) step("R8 count after select");
    sel_d = 2'd2;
    for (int i = 0; i < N_SET + 3; i++) step("R8 restart mid count");
  endtask

  task automatic t_enable();
    oe_d = 1'b1;
    for (int i = 0; i < 8; i++) step("R4 outputs released");
    oe_d = 1'b0;
    for (int i = 0; i < 5; i++) step("R4 R8 outputs driven");
    oe_d = 1'b1;
    step("R4 released again");
    oe_d = 1'b0;
    for (int i = 0; i < N_SET + 3; i++) step("R8 count after enable");
  endtask

  initial begin
    t_reset();
    t_codes();
    t_clear();
    t_bypass();
    t_settle();
    t_enable();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule